// File: doc/BRIEF.md
# Multiply-Unit Dual-Issue Pairing Checker

This block sits in the decode stage of an in-order dual-issue pipeline. It decides whether the two instructions of a fetched pair may issue in the same slot. It only looks at instructions that touch the multiply unit or its result registers. Each slot arrives as a valid bit and a small class code. The block keeps two shared resources apart:

- the multiplier lock, taken by a multiply or by a load into a result register;
- the result read bus, used by every read of a result register.

A read of a result register needs only the read bus. It therefore blocks a second read of a result register, but it does not block a multiply or a load that follows it.

When a pair cannot issue together, the block raises a one-slot stall request for the younger instruction. It keeps that instruction in an internal hold register. On the next cycle the held instruction takes the older position, and the younger input slot supplies its partner. The block has no datapath and does no opcode decoding beyond the class code.

Top module: `mulpath_pair_check`

## Requirements
- R1: After a synchronous active-high reset, no instruction is held and `stall` is 0. The first pair presented issues its older instruction from slot A.
- R2: An older result-read (class 2 = read to register, class 3 = read to memory) followed by a multiply (class 1) or a register-to-result load (class 4) pairs. `pair_ok` is 1 and `stall` is 0.
- R3: An older result-read (class 2 or 3) followed by a memory-to-result load (class 5) pairs.
- R4: Two result-reads in a row (classes 2 or 3 in both positions) do not pair. `stall` is 1, `pair_ok` is 0, and only the older instruction issues on `iss0`.
- R5: On the cycle after a stall, the held younger instruction appears on `iss0` as the older instruction. Slot B gives its partner, and the slot A inputs have no effect on any output.
- R6: The stall lasts one cycle per conflict. After the held cycle, if the pair formed from the held instruction and slot B does not conflict, `stall` is 0 and the block returns to taking its older instruction from slot A.
- R7: An older instruction that takes the multiplier lock (class 1, 4 or 5) followed by any class from 1 to 5 does not pair, and `stall` is 1.
- R8: Class 0 and the unused codes 6 and 7 count as "other". A pair that contains one of them in either position pairs freely.
- R9: With no valid older instruction, `pair_ok` and `stall` are 0. A valid younger instruction then issues alone on `iss0`.
- R10: With no valid younger instruction, `pair_ok` and `stall` are 0, and the older instruction issues alone.
- R11: `iss1_vld` is 1 only when the pair issues. `iss1_cls` is then the younger class, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_vld | input | 1 | Older fetched instruction valid |
| a_cls | input | 3 | Older fetched instruction class |
| b_vld | input | 1 | Younger fetched instruction valid |
| b_cls | input | 3 | Younger fetched instruction class |
| pair_ok | output | 1 | Both instructions issue together |
| stall | output | 1 | Younger instruction waits one slot |
| iss0_vld | output | 1 | Instruction issued in the first position |
| iss0_cls | output | 3 | Class issued in the first position |
| iss1_vld | output | 1 | Instruction issued in the second position |
| iss1_cls | output | 3 | Class issued in the second position |

## Verification
The bench uses the default class width of three bits. At this width all eight codes can be driven, including the unused codes 6 and 7, so the "other" handling of R8 is covered for every code. A long run of random pairs also produces conflicts back to back: a held instruction meets a fresh younger instruction that conflicts again. This exercises the rule of one stall per conflict under repeated holds as well as the directed pairs.

// File: rtl/mulpath_pkg.sv
package mulpath_pkg;
    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] CLS_OTHER  = 3'd0;
    localparam logic [CLS_W-1:0] CLS_MUL    = 3'd1;
    localparam logic [CLS_W-1:0] CLS_RD_REG = 3'd2;
    localparam logic [CLS_W-1:0] CLS_RD_MEM = 3'd3;
    localparam logic [CLS_W-1:0] CLS_LD_REG = 3'd4;
    localparam logic [CLS_W-1:0] CLS_LD_MEM = 3'd5;

    typedef struct packed {
        logic vld;
        logic [CLS_W-1:0] cls;
    } slot_t;

    // resource usage of one instruction
    typedef struct packed {
        logic locks;    // takes the multiplier lock
        logic touches;  // needs the multiplier or its result registers
        logic rd_bus;   // drives the result read bus
    } use_t;

    typedef struct packed {
        slot_t hold;
    } state_t;
endpackage

// File: rtl/mulpath_cls_dec.sv
module mulpath_cls_dec
    import mulpath_pkg::*;
(
    input  slot_t slot_i,
    output use_t  use_o
);
    always_comb begin
        use_o = '0;
        if (slot_i.vld) begin
            case (slot_i.cls)
                CLS_MUL, CLS_LD_REG, CLS_LD_MEM: begin
                    use_o.locks   = 1'b1;
                    use_o.touches = 1'b1;
                end
                CLS_RD_REG, CLS_RD_MEM: begin
                    use_o.rd_bus  = 1'b1;
                    use_o.touches = 1'b1;
                end
                default: use_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/mulpath_conflict.sv
module mulpath_conflict
    import mulpath_pkg::*;
(
    input  use_t old_u,
    input  use_t yng_u,
    output logic bus_clash,
    output logic lock_clash,
    output logic clash
);
    always_comb begin
        bus_clash  = old_u.rd_bus & yng_u.rd_bus;
        lock_clash = old_u.locks  & yng_u.touches;
        clash      = bus_clash | lock_clash;
    end

    // a read never takes the lock, so the two causes cannot coincide
    always_comb begin
        a_excl_r7: assert (!(bus_clash && lock_clash));
    end
endmodule

// File: rtl/mulpath_pair_check.sv
module mulpath_pair_check
    import mulpath_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             a_vld,
    input  logic [CLS_W-1:0] a_cls,
    input  logic             b_vld,
    input  logic [CLS_W-1:0] b_cls,
    output logic             pair_ok,
    output logic             stall,
    output logic             iss0_vld,
    output logic [CLS_W-1:0] iss0_cls,
    output logic             iss1_vld,
    output logic [CLS_W-1:0] iss1_cls
);
    localparam int NSLOT = 2;

    state_t st_d, st_q;
    slot_t  eff [NSLOT];
    use_t   use_w [NSLOT];
    logic   bus_clash, lock_clash, clash;

    always_comb begin
        eff[0] = st_q.hold.vld ? st_q.hold : slot_t'{a_vld, a_cls};
        eff[1] = slot_t'{b_vld, b_cls};
    end

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_dec
        mulpath_cls_dec u_dec (
            .slot_i (eff[gi]),
            .use_o  (use_w[gi])
        );
    end

    mulpath_conflict u_conf (
        .old_u      (use_w[0]),
        .yng_u      (use_w[1]),
        .bus_clash  (bus_clash),
        .lock_clash (lock_clash),
        .clash      (clash)
    );

    always_comb begin
        st_d     = '0;
        pair_ok  = 1'b0;
        stall    = 1'b0;
        iss0_vld = 1'b0;
        iss0_cls = '0;
        iss1_vld = 1'b0;
        iss1_cls = '0;
        if (eff[0].vld) begin
            iss0_vld = 1'b1;
            iss0_cls = eff[0].cls;
            if (eff[1].vld) begin
                if (clash) begin
                    stall     = 1'b1;
                    st_d.hold = eff[1];
                end else begin
                    pair_ok  = 1'b1;
                    iss1_vld = 1'b1;
                    iss1_cls = eff[1].cls;
                end
            end
        end else if (eff[1].vld) begin
            iss0_vld = 1'b1;
            iss0_cls = eff[1].cls;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // assertions
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(pair_ok && stall));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        stall |=> (iss0_vld && iss0_cls == $past(b_cls)));

    p_readpair_r2: assert property (@(posedge clk) disable iff (rst)
        (eff[0].vld && eff[1].vld && use_w[0].rd_bus && !use_w[1].rd_bus) |-> pair_ok);

    p_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (use_w[0].rd_bus && use_w[1].rd_bus) |-> stall);

    p_noold_r9: assert property (@(posedge clk) disable iff (rst)
        (!st_q.hold.vld && !a_vld) |-> (!pair_ok && !stall));

    p_noyng_r10: assert property (@(posedge clk) disable iff (rst)
        !b_vld |-> (!pair_ok && !stall && !iss1_vld));
endmodule

// File: tb/mulpath_pair_check_tb.sv
module mulpath_pair_check_tb;
    logic clk = 1'b0;
    logic rst;
    logic a_vld, b_vld;
    logic [2:0] a_cls, b_cls;
    logic pair_ok, stall, iss0_vld, iss1_vld;
    logic [2:0] iss0_cls, iss1_cls;

    int n_run = 0;
    int n_fail = 0;
    bit m_hv = 0;
    int m_hc = 0;

    always #5 clk = ~clk;

    mulpath_pair_check u_dut (
        .clk(clk), .rst(rst),
        .a_vld(a_vld), .a_cls(a_cls), .b_vld(b_vld), .b_cls(b_cls),
        .pair_ok(pair_ok), .stall(stall),
        .iss0_vld(iss0_vld), .iss0_cls(iss0_cls),
        .iss1_vld(iss1_vld), .iss1_cls(iss1_cls)
    );

    function automatic bit conflicts(int o, int y);
        bit both_read = (o == 2 || o == 3) && (y == 2 || y == 3);
        bit lock_hit  = (o == 1 || o == 4 || o == 5) && (y >= 1 && y <= 5);
        return both_read || lock_hit;
    endfunction

    task automatic step(input bit av, input int ac, input bit bv, input int bc,
                        input string tag);
        bit ov, e_pair, e_stall, e_v0, e_v1;
        int oc, e_c0, e_c1;
        @(negedge clk);
        a_vld = av; a_cls = 3'(ac); b_vld = bv; b_cls = 3'(bc);
        #2;
        ov = m_hv ? 1'b1 : av;
        oc = m_hv ? m_hc : ac;
        e_pair = 0; e_stall = 0; e_v0 = 0; e_c0 = 0; e_v1 = 0; e_c1 = 0;
        if (ov) begin
            e_v0 = 1; e_c0 = oc;
            if (bv) begin
                if (conflicts(oc, bc)) e_stall = 1;
                else begin e_pair = 1; e_v1 = 1; e_c1 = bc; end
            end
        end else if (bv) begin
            e_v0 = 1; e_c0 = bc;
        end
        n_run++;
        if (pair_ok !== e_pair || stall !== e_stall || iss0_vld !== e_v0 ||
            (e_v0 && int'(iss0_cls) != e_c0) || iss1_vld !== e_v1 ||
            int'(iss1_cls) != e_c1) begin
            n_fail++;
            $display("FAIL %s act pair=%0b stall=%0b i0=%0b/%0d i1=%0b/%0d exp pair=%0b stall=%0b i0=%0b/%0d i1=%0b/%0d",
                     tag, pair_ok, stall, iss0_vld, iss0_cls, iss1_vld, iss1_cls,
                     e_pair, e_stall, e_v0, e_c0, e_v1, e_c1);
        end
        @(posedge clk);
        m_hv = e_stall;
        m_hc = bc;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog act hung exp done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; a_vld = 1; a_cls = 3'd2; b_vld = 1; b_cls = 3'd3;
        repeat (3) @(posedge clk);
        #1 rst = 0; m_hv = 0;
        step(1, 2, 1, 0, "R1");
        step(1, 2, 1, 1, "R2");
        step(1, 2, 1, 4, "R2");
        step(1, 3, 1, 1, "R2");
        step(1, 2, 1, 5, "R3");
        step(1, 3, 1, 5, "R3");
        step(1, 2, 1, 3, "R4");
        step(1, 1, 1, 0, "R5");   // held read 3 + other; slot A ignored
        step(1, 4, 1, 1, "R6");   // back to slot A: lock + multiply stalls
        step(0, 0, 1, 0, "R5");   // held multiply + other, slot A invalid ignored
        step(1, 0, 1, 0, "R6");
        step(1, 1, 1, 1, "R7");
        step(1, 7, 1, 0, "R5");
        step(1, 4, 1, 2, "R7");
        step(1, 2, 1, 6, "R5");
        step(1, 5, 1, 1, "R7");
        step(1, 7, 1, 7, "R5");
        step(1, 1, 1, 3, "R7");
        step(1, 0, 1, 0, "R5");
        step(1, 0, 1, 1, "R8");
        step(1, 1, 1, 0, "R8");
        step(1, 6, 1, 3, "R8");
        step(1, 7, 1, 7, "R8");
        step(0, 2, 1, 2, "R9");
        step(0, 0, 0, 0, "R9");
        step(1, 2, 0, 3, "R10");
        step(1, 1, 0, 1, "R10");
        step(1, 2, 1, 2, "R4");
        step(1, 0, 1, 3, "R4");   // held read meets read again: second stall
        step(1, 0, 1, 1, "R6");   // held read + multiply pairs
        for (int i = 0; i < 3000; i++)
            step(bit'($urandom_range(0, 5) != 0), int'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 5) != 0), int'($urandom_range(0, 7)), "R11");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule